// File: doc/BRIEF.md
# Two-Phase Bitmap Redundancy Analyzer

This block chooses spare rows and spare columns (or column groups) for a repairable memory while its self-test is still running. Each failing cell reported by the test engine goes into a small local bitmap. The bitmap has a set of row address registers and a set of column address registers, and one fault bit for every row/column register pair. The block never holds a full fault map. It applies must-repair rules after every fault. When the bitmap runs out of row registers or column registers, it allocates greedily, repairing the line that holds the most faults. The self-test is held off through a ready signal while the analyzer works.

A read word that shows faults in more than one column group is repaired with a spare row at once. A fault that falls on a row or column already covered by a spare is dropped. When the test engine signals completion, the analyzer drains the bitmap with the same rules and then raises done. It reports the allocated spare addresses and a sticky unrepairable flag, which is set when a repair is needed and no spare of the required kind is left.

Top module: `redund_analyzer`

## Requirements
- R1: `ready_o` is 1 only while faults are accepted. It is 1 after reset. A fault presented with `ready_o` high is taken at that edge, and `ready_o` is 0 in the next cycle. `ready_o` and `done_o` are never 1 together.
- R2: Faults that share a row address share one row register, and faults that share a column address share one column register. Line fault counts are therefore counts per address. For example, faults (7,1) and (8,1) give column 1 a count of 2.
- R3: Row must-repair: when a bitmap row holds more faults than there are spare columns left, that row receives a spare row. A row with 3 faults, with 2 spare columns free, is repaired by a spare row.
- R4: Column must-repair: when a bitmap column holds more faults than there are spare rows left, that column receives a spare column. Row must-repair is checked before column must-repair, and the lowest register index is taken first.
- R5: When every row register or every column register is in use, the analyzer applies repair-most: the line with the highest fault count gets a spare. On a tie between a row and a column, the row wins. Between equal rows, or between equal columns, the lowest register index wins. The repaired line's faults leave the bitmap.
- R6: A fault flagged as multi-subword (`fault_multi_i`=1) takes a spare row for its row address directly, and any bitmap entries of that row are removed.
- R7: A fault whose row address equals an allocated spare row, or whose column address equals an allocated spare column, is discarded and leaves no entry in the bitmap.
- R8: If a repair needs a spare of a kind that is exhausted, `unrepairable_o` rises and stays high until reset. Later faults are accepted and ignored.
- R9: After `test_done_i` is seen while the analyzer is idle, the remaining bitmap is drained with the must-repair and repair-most rules. `done_o` then rises and stays high, and `ready_o` stays 0.
- R10: Spares are used in index order, starting at 0. Spare k's address sits at bits [k*W +: W] of its address port. Spare valid bits only rise, and an allocated spare's address never changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fault_valid_i | input | 1 | A failing cell is presented |
| fault_row_i | input | ROW_W | Row address of the failing cell |
| fault_col_i | input | COL_W | Column (group) address of the failing cell |
| fault_multi_i | input | 1 | The failing word has several faulty subwords |
| test_done_i | input | 1 | Self-test finished; run the final allocation |
| ready_o | output | 1 | Fault accepted at this edge; low stalls the test |
| done_o | output | 1 | Analysis finished |
| unrepairable_o | output | 1 | Spares are insufficient |
| row_spare_vld_o | output | NUM_SR | Spare row k is allocated |
| row_spare_addr_o | output | NUM_SR*ROW_W | Row address assigned to each spare row |
| col_spare_vld_o | output | NUM_SC | Spare column k is allocated |
| col_spare_addr_o | output | NUM_SC*COL_W | Column address assigned to each spare column |

## Verification
A fault is taken at the rising edge where `ready_o` is high. `ready_o` is low in the following cycle. Each allocation then takes exactly one further cycle, and its spare valid bit and address appear after that edge. Once no rule fires, `ready_o` returns one cycle later. `done_o` rises one cycle after the allocation step that leaves the bitmap empty. The bench changes inputs and samples outputs only on falling edges. It steps a behavioural reference model on each rising edge and compares every output with the model on each falling edge. Directed end-of-scenario checks use hand-computed spare addresses.

// File: rtl/bra_pkg.sv
package bra_pkg;
  typedef enum logic [1:0] {ACT_NONE, ACT_ROW, ACT_COL, ACT_FAIL} act_e;
  typedef enum logic [1:0] {ST_IDLE, ST_ALLOC, ST_FINAL, ST_DONE} st_e;
endpackage

// File: rtl/bra_bitmap.sv
module bra_bitmap #(
  parameter int ROW_W   = 6,
  parameter int COL_W   = 3,
  parameter int BM_ROWS = 4,
  parameter int BM_COLS = 5,
  localparam int RI_W = $clog2(BM_ROWS),
  localparam int CI_W = $clog2(BM_COLS)
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [ROW_W-1:0]                   look_row_i,
  input  logic [COL_W-1:0]                   look_col_i,
  input  logic                               ins_i,
  input  logic                               clr_row_i,
  input  logic [RI_W-1:0]                    clr_row_idx_i,
  input  logic                               clr_col_i,
  input  logic [CI_W-1:0]                    clr_col_idx_i,
  output logic [BM_ROWS-1:0][BM_COLS-1:0]    bits_o,
  output logic [BM_ROWS-1:0][ROW_W-1:0]      row_addr_o,
  output logic                               row_hit_o,
  output logic [RI_W-1:0]                    row_hit_idx_o
);
  logic [BM_ROWS-1:0][BM_COLS-1:0] bits_q;
  logic [BM_ROWS-1:0][ROW_W-1:0]   row_addr_q;
  logic [BM_COLS-1:0][COL_W-1:0]   col_addr_q;
  logic [BM_ROWS-1:0]              row_used;
  logic [BM_COLS-1:0]              col_used;
  logic [RI_W-1:0]                 row_free, row_tgt;
  logic [CI_W-1:0]                 col_free, col_tgt, col_hit_idx;
  logic                            col_hit;

  // a register is in use exactly when it still owns a fault bit
  always_comb begin
    col_used = '0;
    for (int i = 0; i < BM_ROWS; i++) begin
      row_used[i] = |bits_q[i];
      col_used    = col_used | bits_q[i];
    end
  end

  always_comb begin
    row_hit_o = 1'b0; row_hit_idx_o = '0; row_free = '0;
    col_hit = 1'b0; col_hit_idx = '0; col_free = '0;
    for (int i = BM_ROWS-1; i >= 0; i--) begin
      if (!row_used[i]) row_free = RI_W'(i);
      if (row_used[i] && row_addr_q[i] == look_row_i) begin
        row_hit_o = 1'b1; row_hit_idx_o = RI_W'(i);
      end
    end
    for (int j = BM_COLS-1; j >= 0; j--) begin
      if (!col_used[j]) col_free = CI_W'(j);
      if (col_used[j] && col_addr_q[j] == look_col_i) begin
        col_hit = 1'b1; col_hit_idx = CI_W'(j);
      end
    end
    row_tgt = row_hit_o ? row_hit_idx_o : row_free;
    col_tgt = col_hit ? col_hit_idx : col_free;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bits_q     <= '0;
      row_addr_q <= '0;
      col_addr_q <= '0;
    end else begin
      if (ins_i) begin
        if (!row_hit_o) row_addr_q[row_free] <= look_row_i;
        if (!col_hit)   col_addr_q[col_free] <= look_col_i;
        bits_q[row_tgt][col_tgt] <= 1'b1;
      end
      if (clr_row_i) bits_q[clr_row_idx_i] <= '0;
      if (clr_col_i)
        for (int i = 0; i < BM_ROWS; i++) bits_q[i][clr_col_idx_i] <= 1'b0;
    end
  end

  assign bits_o     = bits_q;
  assign row_addr_o = row_addr_q;
endmodule

// File: rtl/bra_select.sv
module bra_select import bra_pkg::*; #(
  parameter int BM_ROWS = 4,
  parameter int BM_COLS = 5,
  parameter int AVR_W   = 2,
  parameter int AVC_W   = 2,
  localparam int RI_W = $clog2(BM_ROWS),
  localparam int CI_W = $clog2(BM_COLS)
) (
  input  logic [BM_ROWS-1:0][BM_COLS-1:0] bits_i,
  input  logic [AVR_W-1:0]                nr_avail_i,
  input  logic [AVC_W-1:0]                nc_avail_i,
  input  logic                            final_i,
  output act_e                            act_o,
  output logic [RI_W-1:0]                 row_idx_o,
  output logic [CI_W-1:0]                 col_idx_o
);
  int row_cnt [BM_ROWS];
  int col_cnt [BM_COLS];

  always_comb begin
    for (int i = 0; i < BM_ROWS; i++) row_cnt[i] = $countones(bits_i[i]);
    for (int j = 0; j < BM_COLS; j++) begin
      col_cnt[j] = 0;
      for (int i = 0; i < BM_ROWS; i++) col_cnt[j] += 32'(bits_i[i][j]);
    end
  end

  always_comb begin
    int avr, avc, rmax, cmax;
    logic mrow_ok, mcol_ok, all_r, all_c, any_r;
    logic [RI_W-1:0] mrow, brow;
    logic [CI_W-1:0] mcol, bcol;
    avr = 32'(nr_avail_i);
    avc = 32'(nc_avail_i);
    mrow_ok = 1'b0; mrow = '0; brow = '0; rmax = 0;
    mcol_ok = 1'b0; mcol = '0; bcol = '0; cmax = 0;
    all_r = 1'b1; all_c = 1'b1; any_r = 1'b0;
    for (int i = BM_ROWS-1; i >= 0; i--)
      if (row_cnt[i] > avc) begin mrow_ok = 1'b1; mrow = RI_W'(i); end
    for (int j = BM_COLS-1; j >= 0; j--)
      if (col_cnt[j] > avr) begin mcol_ok = 1'b1; mcol = CI_W'(j); end
    for (int i = 0; i < BM_ROWS; i++) begin
      if (row_cnt[i] > rmax) begin rmax = row_cnt[i]; brow = RI_W'(i); end
      if (row_cnt[i] == 0) all_r = 1'b0; else any_r = 1'b1;
    end
    for (int j = 0; j < BM_COLS; j++) begin
      if (col_cnt[j] > cmax) begin cmax = col_cnt[j]; bcol = CI_W'(j); end
      if (col_cnt[j] == 0) all_c = 1'b0;
    end
    if (mrow_ok)                              act_o = (avr != 0) ? ACT_ROW : ACT_FAIL;
    else if (mcol_ok)                         act_o = (avc != 0) ? ACT_COL : ACT_FAIL;
    else if (!any_r || (!final_i && !all_r && !all_c)) act_o = ACT_NONE;
    else if (avr != 0 && (avc == 0 || rmax >= cmax))   act_o = ACT_ROW;
    else if (avc != 0)                        act_o = ACT_COL;
    else                                      act_o = ACT_FAIL;
    row_idx_o = mrow_ok ? mrow : brow;
    col_idx_o = mcol_ok ? mcol : bcol;
  end
endmodule

// File: rtl/redund_analyzer.sv
module redund_analyzer import bra_pkg::*; #(
  parameter int ROW_W   = 6,
  parameter int COL_W   = 3,
  parameter int NUM_SR  = 2,
  parameter int NUM_SC  = 2,
  parameter int BM_ROWS = 4,
  parameter int BM_COLS = 5
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      fault_valid_i,
  input  logic [ROW_W-1:0]          fault_row_i,
  input  logic [COL_W-1:0]          fault_col_i,
  input  logic                      fault_multi_i,
  input  logic                      test_done_i,
  output logic                      ready_o,
  output logic                      done_o,
  output logic                      unrepairable_o,
  output logic [NUM_SR-1:0]         row_spare_vld_o,
  output logic [NUM_SR*ROW_W-1:0]   row_spare_addr_o,
  output logic [NUM_SC-1:0]         col_spare_vld_o,
  output logic [NUM_SC*COL_W-1:0]   col_spare_addr_o
);
  localparam int RI_W  = $clog2(BM_ROWS);
  localparam int CI_W  = $clog2(BM_COLS);
  localparam int SR_CW = $clog2(NUM_SR+1);
  localparam int SC_CW = $clog2(NUM_SC+1);

  st_e                              st_q, st_d;
  logic                             unrep_q;
  logic [SR_CW-1:0]                 nr_q, nr_avail;
  logic [SC_CW-1:0]                 nc_q, nc_avail;
  logic [NUM_SR-1:0][ROW_W-1:0]     row_sp_q;
  logic [NUM_SC-1:0][COL_W-1:0]     col_sp_q;
  logic [BM_ROWS-1:0][BM_COLS-1:0]  bits;
  logic [BM_ROWS-1:0][ROW_W-1:0]    row_addr;
  logic                             row_hit, covered, take, step, multi_ok, fail_now;
  logic                             ins, clr_row, alloc_row, alloc_col;
  logic [RI_W-1:0]                  row_hit_idx, sel_row, clr_row_idx;
  logic [CI_W-1:0]                  sel_col;
  logic [ROW_W-1:0]                 new_row_addr;
  act_e                             act;

  assign nr_avail = SR_CW'(NUM_SR) - nr_q;
  assign nc_avail = SC_CW'(NUM_SC) - nc_q;

  always_comb begin
    covered = 1'b0;
    for (int k = 0; k < NUM_SR; k++)
      if (SR_CW'(k) < nr_q && row_sp_q[k] == fault_row_i) covered = 1'b1;
    for (int k = 0; k < NUM_SC; k++)
      if (SC_CW'(k) < nc_q && col_sp_q[k] == fault_col_i) covered = 1'b1;
  end

  assign take         = st_q == ST_IDLE && fault_valid_i && !unrep_q && !covered;
  assign step         = (st_q == ST_ALLOC || st_q == ST_FINAL) && !unrep_q;
  assign multi_ok     = take && fault_multi_i && nr_avail != '0;
  assign ins          = take && !fault_multi_i;
  assign alloc_row    = multi_ok || (step && act == ACT_ROW);
  assign alloc_col    = step && act == ACT_COL;
  assign clr_row      = (multi_ok && row_hit) || (step && act == ACT_ROW);
  assign clr_row_idx  = multi_ok ? row_hit_idx : sel_row;
  assign new_row_addr = multi_ok ? fault_row_i : row_addr[sel_row];
  assign fail_now     = (take && fault_multi_i && nr_avail == '0) || (step && act == ACT_FAIL);

  bra_bitmap #(.ROW_W(ROW_W), .COL_W(COL_W), .BM_ROWS(BM_ROWS), .BM_COLS(BM_COLS)) u_bitmap (
    .clk_i, .rst_ni,
    .look_row_i(fault_row_i), .look_col_i(fault_col_i), .ins_i(ins),
    .clr_row_i(clr_row), .clr_row_idx_i(clr_row_idx),
    .clr_col_i(alloc_col), .clr_col_idx_i(sel_col),
    .bits_o(bits), .row_addr_o(row_addr),
    .row_hit_o(row_hit), .row_hit_idx_o(row_hit_idx)
  );

  bra_select #(.BM_ROWS(BM_ROWS), .BM_COLS(BM_COLS), .AVR_W(SR_CW), .AVC_W(SC_CW)) u_select (
    .bits_i(bits), .nr_avail_i(nr_avail), .nc_avail_i(nc_avail),
    .final_i(st_q == ST_FINAL), .act_o(act), .row_idx_o(sel_row), .col_idx_o(sel_col)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (fault_valid_i) st_d = ST_ALLOC;
                else if (test_done_i) st_d = ST_FINAL;
      ST_ALLOC: if (unrep_q || act == ACT_NONE || act == ACT_FAIL) st_d = ST_IDLE;
      ST_FINAL: if (unrep_q || act == ACT_NONE || act == ACT_FAIL) st_d = ST_DONE;
      default:  st_d = ST_DONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      unrep_q  <= 1'b0;
      nr_q     <= '0;
      nc_q     <= '0;
      row_sp_q <= '0;
      col_sp_q <= '0;
    end else begin
      st_q    <= st_d;
      unrep_q <= unrep_q | fail_now;
      if (alloc_row) begin
        for (int k = 0; k < NUM_SR; k++)
          if (SR_CW'(k) == nr_q) row_sp_q[k] <= new_row_addr;
        nr_q <= nr_q + 1'b1;
      end
      if (alloc_col) begin
        for (int k = 0; k < NUM_SC; k++)
          if (SC_CW'(k) == nc_q) col_sp_q[k] <= (COL_W)'(0) | u_bitmap.col_addr_q[sel_col];
        nc_q <= nc_q + 1'b1;
      end
    end
  end

  assign ready_o        = st_q == ST_IDLE;
  assign done_o         = st_q == ST_DONE;
  assign unrepairable_o = unrep_q;

  for (genvar k = 0; k < NUM_SR; k++) begin : g_rsp
    assign row_spare_vld_o[k]                  = SR_CW'(k) < nr_q;
    assign row_spare_addr_o[k*ROW_W +: ROW_W]  = row_sp_q[k];
  end
  for (genvar k = 0; k < NUM_SC; k++) begin : g_csp
    assign col_spare_vld_o[k]                  = SC_CW'(k) < nc_q;
    assign col_spare_addr_o[k*COL_W +: COL_W]  = col_sp_q[k];
  end
endmodule

// File: rtl/bra_chk.sv
module bra_chk #(
  parameter int ROW_W  = 6,
  parameter int COL_W  = 3,
  parameter int NUM_SR = 2,
  parameter int NUM_SC = 2
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    fault_valid_i,
  input logic                    ready_o,
  input logic                    done_o,
  input logic                    unrepairable_o,
  input logic [NUM_SR-1:0]       row_spare_vld_o,
  input logic [NUM_SR*ROW_W-1:0] row_spare_addr_o,
  input logic [NUM_SC-1:0]       col_spare_vld_o,
  input logic [NUM_SC*COL_W-1:0] col_spare_addr_o
);
  // R1
  accept_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_valid_i && ready_o) |=> !ready_o);
  // R1
  ready_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ready_o && done_o));
  // R8
  unrep_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unrepairable_o |=> unrepairable_o);
  // R9
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (done_o && !ready_o));
  // R10
  row_vld_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|row_spare_vld_o) |=> ((row_spare_vld_o & $past(row_spare_vld_o)) == $past(row_spare_vld_o)));
  // R10
  col_vld_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|col_spare_vld_o) |=> ((col_spare_vld_o & $past(col_spare_vld_o)) == $past(col_spare_vld_o)));
  // R10
  row_vld_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((row_spare_vld_o & (row_spare_vld_o + 1'b1)) == '0));
  // R10
  col_vld_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((col_spare_vld_o & (col_spare_vld_o + 1'b1)) == '0));

  for (genvar k = 0; k < NUM_SR; k++) begin : g_ra
    // R10
    row_addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      row_spare_vld_o[k] |=> $stable(row_spare_addr_o[k*ROW_W +: ROW_W]));
  end
  for (genvar k = 0; k < NUM_SC; k++) begin : g_ca
    // R10
    col_addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      col_spare_vld_o[k] |=> $stable(col_spare_addr_o[k*COL_W +: COL_W]));
  end
endmodule

bind redund_analyzer bra_chk #(.ROW_W(ROW_W), .COL_W(COL_W), .NUM_SR(NUM_SR), .NUM_SC(NUM_SC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fault_valid_i(fault_valid_i), .ready_o(ready_o),
  .done_o(done_o), .unrepairable_o(unrepairable_o),
  .row_spare_vld_o(row_spare_vld_o), .row_spare_addr_o(row_spare_addr_o),
  .col_spare_vld_o(col_spare_vld_o), .col_spare_addr_o(col_spare_addr_o)
);

// File: tb/tb_redund_analyzer.sv
`timescale 1ns/1ps
module tb_redund_analyzer;
  localparam int ROW_W = 6, COL_W = 3, NSR = 2, NSC = 2, BR = 4, BC = 5;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic fault_valid = 1'b0, fault_multi = 1'b0, test_done = 1'b0;
  logic [ROW_W-1:0] fault_row = '0;
  logic [COL_W-1:0] fault_col = '0;
  logic ready, done, unrep;
  logic [NSR-1:0] rs_vld;
  logic [NSR*ROW_W-1:0] rs_addr;
  logic [NSC-1:0] cs_vld;
  logic [NSC*COL_W-1:0] cs_addr;

  always #2.5 clk = ~clk;

  redund_analyzer #(.ROW_W(ROW_W), .COL_W(COL_W), .NUM_SR(NSR), .NUM_SC(NSC),
                    .BM_ROWS(BR), .BM_COLS(BC)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .fault_valid_i(fault_valid), .fault_row_i(fault_row),
    .fault_col_i(fault_col), .fault_multi_i(fault_multi), .test_done_i(test_done),
    .ready_o(ready), .done_o(done), .unrepairable_o(unrep),
    .row_spare_vld_o(rs_vld), .row_spare_addr_o(rs_addr),
    .col_spare_vld_o(cs_vld), .col_spare_addr_o(cs_addr));

  int total = 0, bad = 0, cyc = 0;
  string cur_req = "R1";

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int m_st, m_unrep, m_nsr, m_nsc;
  int m_bits [BR][BC];
  int m_ra [BR];
  int m_ca [BC];
  int m_sr [NSR];
  int m_sc [NSC];

  function automatic bit m_rowv(int i);
    for (int j = 0; j < BC; j++) if (m_bits[i][j] != 0) return 1'b1;
    return 1'b0;
  endfunction
  function automatic bit m_colv(int j);
    for (int i = 0; i < BR; i++) if (m_bits[i][j] != 0) return 1'b1;
    return 1'b0;
  endfunction

  task automatic m_reset();
    m_st = 0; m_unrep = 0; m_nsr = 0; m_nsc = 0;
    for (int i = 0; i < BR; i++) begin m_ra[i] = 0; for (int j = 0; j < BC; j++) m_bits[i][j] = 0; end
    for (int j = 0; j < BC; j++) m_ca[j] = 0;
    for (int k = 0; k < NSR; k++) m_sr[k] = 0;
    for (int k = 0; k < NSC; k++) m_sc[k] = 0;
  endtask

  task automatic m_take_row(int i);
    m_sr[m_nsr] = m_ra[i]; m_nsr++;
    for (int j = 0; j < BC; j++) m_bits[i][j] = 0;
  endtask
  task automatic m_take_col(int j);
    m_sc[m_nsc] = m_ca[j]; m_nsc++;
    for (int i = 0; i < BR; i++) m_bits[i][j] = 0;
  endtask

  // returns 0 nothing done, 1 spare used, 3 out of spares
  task automatic m_step(input bit fin, output int res);
    int rc [BR];
    int cc [BC];
    int avr, avc, mr, mc, rmax, cmax, ri, ci, nr, ncu;
    avr = NSR - m_nsr; avc = NSC - m_nsc;
    nr = 0; ncu = 0;
    for (int i = 0; i < BR; i++) begin rc[i] = 0; for (int j = 0; j < BC; j++) rc[i] += m_bits[i][j]; if (rc[i] > 0) nr++; end
    for (int j = 0; j < BC; j++) begin cc[j] = 0; for (int i = 0; i < BR; i++) cc[j] += m_bits[i][j]; if (cc[j] > 0) ncu++; end
    mr = -1; mc = -1;
    for (int i = 0; i < BR; i++) if (mr < 0 && rc[i] > avc) mr = i;
    for (int j = 0; j < BC; j++) if (mc < 0 && cc[j] > avr) mc = j;
    res = 1;
    if (mr >= 0) begin if (avr > 0) m_take_row(mr); else res = 3; end
    else if (mc >= 0) begin if (avc > 0) m_take_col(mc); else res = 3; end
    else if (nr == 0 || (!fin && nr < BR && ncu < BC)) res = 0;
    else begin
      rmax = 0; cmax = 0; ri = 0; ci = 0;
      for (int i = 0; i < BR; i++) if (rc[i] > rmax) begin rmax = rc[i]; ri = i; end
      for (int j = 0; j < BC; j++) if (cc[j] > cmax) begin cmax = cc[j]; ci = j; end
      if (avr > 0 && (avc == 0 || rmax >= cmax)) m_take_row(ri);
      else if (avc > 0) m_take_col(ci);
      else res = 3;
    end
  endtask

  task automatic m_fault(int r, int c, bit mul);
    int rh, ch;
    bit cov;
    cov = 1'b0;
    for (int k = 0; k < m_nsr; k++) if (m_sr[k] == r) cov = 1'b1;
    for (int k = 0; k < m_nsc; k++) if (m_sc[k] == c) cov = 1'b1;
    if (m_unrep != 0 || cov) return;
    if (mul) begin
      if (m_nsr < NSR) begin
        m_sr[m_nsr] = r; m_nsr++;
        for (int i = 0; i < BR; i++) if (m_rowv(i) && m_ra[i] == r)
          for (int j = 0; j < BC; j++) m_bits[i][j] = 0;
      end else m_unrep = 1;
      return;
    end
    rh = -1; ch = -1;
    for (int i = 0; i < BR; i++) if (rh < 0 && m_rowv(i) && m_ra[i] == r) rh = i;
    for (int j = 0; j < BC; j++) if (ch < 0 && m_colv(j) && m_ca[j] == c) ch = j;
    if (rh < 0) for (int i = BR-1; i >= 0; i--) if (!m_rowv(i)) rh = i;
    if (ch < 0) for (int j = BC-1; j >= 0; j--) if (!m_colv(j)) ch = j;
    m_ra[rh] = r; m_ca[ch] = c;
    m_bits[rh][ch] = 1;
  endtask

  always @(posedge clk or negedge rst_ni) begin
    int res;
    if (!rst_ni) m_reset();
    else begin
      case (m_st)
        0: if (fault_valid) begin m_fault(int'(fault_row), int'(fault_col), fault_multi); m_st = 1; end
           else if (test_done) m_st = 2;
        1: if (m_unrep != 0) m_st = 0;
           else begin m_step(1'b0, res); if (res == 0) m_st = 0; else if (res == 3) begin m_unrep = 1; m_st = 0; end end
        2: if (m_unrep != 0) m_st = 3;
           else begin m_step(1'b1, res); if (res == 0) m_st = 3; else if (res == 3) begin m_unrep = 1; m_st = 3; end end
        default: m_st = 3;
      endcase
    end
  end

  // compare against the model on every falling edge
  always @(negedge clk) begin
    logic [NSR-1:0] ev_r; logic [NSC-1:0] ev_c;
    logic [NSR*ROW_W-1:0] ea_r; logic [NSC*COL_W-1:0] ea_c;
    if (rst_ni) begin
      ev_r = '0; ev_c = '0; ea_r = '0; ea_c = '0;
      for (int k = 0; k < NSR; k++) begin
        if (k < m_nsr) ev_r[k] = 1'b1;
        ea_r[k*ROW_W +: ROW_W] = ROW_W'(m_sr[k]);
      end
      for (int k = 0; k < NSC; k++) begin
        if (k < m_nsc) ev_c[k] = 1'b1;
        ea_c[k*COL_W +: COL_W] = COL_W'(m_sc[k]);
      end
      chk(cur_req, "ready", 32'(ready), 32'(m_st == 0));
      chk(cur_req, "done", 32'(done), 32'(m_st == 3));
      chk(cur_req, "unrepairable", 32'(unrep), 32'(m_unrep));
      chk(cur_req, "row spare vld", 32'(rs_vld), 32'(ev_r));
      chk(cur_req, "row spare addr", 32'(rs_addr), 32'(ea_r));
      chk(cur_req, "col spare vld", 32'(cs_vld), 32'(ev_c));
      chk(cur_req, "col spare addr", 32'(cs_addr), 32'(ea_c));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      bad++; total++;
      $display("FAIL %s watchdog expired", cur_req);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic do_reset();
    rst_ni = 1'b0; fault_valid = 1'b0; test_done = 1'b0; fault_multi = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic send(input int r, input int c, input bit mul);
    bit acc;
    fault_valid = 1'b1; fault_row = ROW_W'(r); fault_col = COL_W'(c); fault_multi = mul;
    forever begin
      acc = ready;
      @(negedge clk);
      if (acc) break;
    end
    fault_valid = 1'b0; fault_multi = 1'b0;
  endtask

  task automatic wait_idle();
    while (!ready && !done) @(negedge clk);
  endtask

  task automatic finish_test();
    wait_idle();
    test_done = 1'b1;
    while (!done) @(negedge clk);
    test_done = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int unsigned x;
    m_reset();
    do_reset();
    cur_req = "R1";
    chk("R1", "reset ready", 32'(ready), 32'd1);
    chk("R1", "reset done", 32'(done), 32'd0);
    chk("R8", "reset unrepairable", 32'(unrep), 32'd0);
    chk("R10", "reset spares", 32'({rs_vld, cs_vld}), 32'd0);

    // R3: three faults in one row beat two free spare columns
    cur_req = "R3";
    send(5, 1, 0); send(5, 2, 0); send(5, 3, 0); wait_idle();
    chk("R3", "row must-repair vld", 32'(rs_vld), 32'b01);
    chk("R3", "row must-repair addr", 32'(rs_addr[ROW_W-1:0]), 32'd5);
    chk("R3", "no column used", 32'(cs_vld), 32'd0);
    cur_req = "R9";
    finish_test();
    chk("R9", "done after empty drain", 32'(done), 32'd1);
    chk("R9", "ready low when done", 32'(ready), 32'd0);

    // R4: three faults in one column beat two free spare rows
    do_reset(); cur_req = "R4";
    send(1, 4, 0); send(2, 4, 0); send(3, 4, 0); wait_idle();
    chk("R4", "col must-repair vld", 32'(cs_vld), 32'b01);
    chk("R4", "col must-repair addr", 32'(cs_addr[COL_W-1:0]), 32'd4);
    chk("R4", "no row used", 32'(rs_vld), 32'd0);

    // R6 and R7: multi-subword row repair, then a covered fault is dropped
    do_reset(); cur_req = "R6";
    send(9, 0, 1); wait_idle();
    chk("R6", "multi row spare", 32'(rs_addr[ROW_W-1:0]), 32'd9);
    cur_req = "R7";
    send(9, 3, 0); finish_test();
    chk("R7", "covered fault left nothing", 32'({rs_vld, cs_vld}), 32'b0100);

    // R5 and R8: repair-most on full bitmap, row wins ties, then spares run out
    do_reset(); cur_req = "R5";
    send(1, 1, 0); send(1, 2, 0); send(2, 3, 0); send(3, 4, 0); send(4, 5, 0); wait_idle();
    chk("R5", "repair-most picks densest row", 32'(rs_addr[ROW_W-1:0]), 32'd1);
    chk("R5", "one row spare", 32'(rs_vld), 32'b01);
    send(6, 6, 0); wait_idle();
    chk("R5", "tie picks lowest row register", 32'(rs_addr), 32'({6'd6, 6'd1}));
    chk("R4", "columns after rows exhausted", 32'(cs_addr), 32'({3'd4, 3'd3}));
    chk("R8", "unrepairable set", 32'(unrep), 32'd1);
    cur_req = "R8";
    send(20, 7, 0); wait_idle();
    chk("R8", "fault ignored rows", 32'(rs_addr), 32'({6'd6, 6'd1}));
    chk("R8", "fault ignored cols", 32'(cs_vld), 32'b11);
    finish_test();
    chk("R8", "still unrepairable", 32'(unrep), 32'd1);

    // R2: shared column register gives column count 2, final drain picks it
    do_reset(); cur_req = "R2";
    send(7, 1, 0); send(8, 1, 0); finish_test();
    chk("R2", "shared column repaired", 32'(cs_vld), 32'b01);
    chk("R2", "shared column addr", 32'(cs_addr[COL_W-1:0]), 32'd1);
    chk("R9", "no row used in drain", 32'(rs_vld), 32'd0);

    // R10: spare rows in order, third multi fault exhausts them
    do_reset(); cur_req = "R10";
    send(12, 0, 1); send(13, 0, 1); wait_idle();
    chk("R10", "rows in order", 32'(rs_addr), 32'({6'd13, 6'd12}));
    send(14, 0, 1); wait_idle();
    chk("R6", "multi without row spare", 32'(unrep), 32'd1);

    // mixed streams compared against the model
    x = 32'h1234_5678;
    for (int round = 0; round < 4; round++) begin
      do_reset(); cur_req = "R2";
      for (int n = 0; n < 30; n++) begin
        x = x * 1103515245 + 12345;
        send(int'((x >> 16) % 8), int'((x >> 8) % 6), ((x >> 4) % 13) == 0);
      end
      finish_test();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule